// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks an SDR SDRAM through its power-up setup without touching the memory pins itself. After reset it waits for an enable that may arrive from any clock domain. It resynchronizes that enable, then lets a parameterized settle delay run out. It then asks a shared cycle state machine, one command at a time, to run a precharge-all, a fixed number of auto-refresh cycles and a mode-register load. Each command is offered as a 2-bit code together with a request strobe. The cycle state machine reports back on a 2-bit cycle-type bus and a step counter. The block treats a command as taken when that machine enters the first step of a command cycle, and as finished when the machine goes idle again.

The 12-bit value for the mode-register load is a constant built from parameters: burst length, burst type, CAS latency and write-burst mode. The shared state machine reads it while it runs the load command. When the last command has completed, a done flag rises and holds until the next reset. The rest of the memory controller waits on this flag before it starts data traffic.

Top module: `sdr_init_seq`

## Requirements
- R1: `mode_word` carries the burst length code in bits [2:0], the burst type in bit 3 (1 = interleaved), the CAS latency in bits [6:4] and the write-burst mode in bit 9 (1 = single-location writes); bits [8:7] and [11:10] are always 0.
- R2: `en_async` passes through SYNC_STAGES flip-flops before use. While the synchronized enable is low and the sequence has not started, `cmd_req` stays low. The first request rises SYNC_STAGES + WAIT_CYCLES + 1 clock edges after `en_async` goes high.
- R3: Once the settle delay has started, later changes of `en_async` have no effect on the sequence.
- R4: Commands are requested in a fixed order: precharge (code 01), then NUM_REFRESH auto-refreshes (code 10), then a mode-register load (code 11).
- R5: A request stays high with an unchanged code until the edge at which `cyc_type` is 01 (command) and `cyc_step` is 0. Cycle types 00, 10 (data) and 11 (refresh), and a command cycle type with a nonzero step, do not count as acceptance.
- R6: `cmd_req` falls on the edge after acceptance. The next request is not raised until `cyc_type` is seen as 00 (idle). It then rises on that same edge.
- R7: `cmd_code` is 00 (no-op) whenever `cmd_req` is low.
- R8: `init_done` rises on the edge at which `cyc_type` is seen idle after the mode-register load was accepted. It then stays high, and no further request is raised, until reset.
- R9: A synchronous active-high `rst` clears `cmd_req`, `cmd_code` and `init_done` and restarts the whole sequence, including enable synchronization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_async | input | 1 | Start enable, asynchronous to `clk` |
| cyc_type | input | 2 | Cycle kind of the shared state machine: 00 idle, 01 command, 10 data, 11 refresh |
| cyc_step | input | STEP_W | Step counter within the current cycle of the shared state machine |
| cmd_code | output | 2 | Requested command: 00 no-op, 01 precharge, 10 auto-refresh, 11 mode-register load |
| cmd_req | output | 1 | Command request strobe, held until accepted |
| mode_word | output | 12 | Value for the mode-register load |
| init_done | output | 1 | Initialization finished, sticky until reset |

## Verification
The assertions assume that the shared state machine follows the handshake. It enters a command cycle only while a request is pending, it starts that cycle at step 0, and it returns to idle before it runs another command cycle. They also assume `rst` is held for at least one edge at power-up. The stimulus works as that machine would: it delays acceptance by varying amounts, and it mixes data cycles, refresh cycles and nonzero-step command cycles into the wait. It always accepts with a step-0 command cycle and ends every command with an idle cycle. The enable is toggled only at the clock's falling edge, so the synchronizer never sees a value change at the active edge.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP       = 2'b00,
        CMD_PRECHARGE = 2'b01,
        CMD_AUTOREF   = 2'b10,
        CMD_LOADMODE  = 2'b11
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'b00,
        CYC_COMMAND = 2'b01,
        CYC_DATA    = 2'b10,
        CYC_REFRESH = 2'b11
    } sdr_cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_BUSY,
        ST_DONE
    } init_state_e;

    // Field order from MSB to LSB; bit positions are what the memory decodes.
    typedef struct packed {
        logic [1:0] rsv_hi;     // [11:10]
        logic       wr_single;  // [9]
        logic [1:0] op_mode;    // [8:7]
        logic [2:0] cas;        // [6:4]
        logic       interleave; // [3]
        logic [2:0] burst;      // [2:0]
    } mode_word_t;

    function automatic mode_word_t build_mode(input int cas_lat, input int burst_code,
                                              input int interleave, input int wr_single);
        mode_word_t m;
        m.rsv_hi     = 2'b00;
        m.wr_single  = (wr_single != 0);
        m.op_mode    = 2'b00;
        m.cas        = 3'(cas_lat);
        m.interleave = (interleave != 0);
        m.burst      = 3'(burst_code);
        return m;
    endfunction

    function automatic sdr_cmd_e cmd_for_slot(input int slot, input int last);
        if (slot == 0)
            return CMD_PRECHARGE;
        else if (slot == last)
            return CMD_LOADMODE;
        else
            return CMD_AUTOREF;
    endfunction

endpackage

// File: rtl/sdr_en_sync.sv
module sdr_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R2: once run out, the count never wraps back up by itself
    p_timer_floor_r2: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
    import sdr_init_pkg::*;
#(
    parameter int NUM_REFRESH = 2,
    parameter int STEP_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_s,
    input  logic              tmr_expired,
    input  logic [1:0]        cyc_type,
    input  logic [STEP_W-1:0] cyc_step,
    output logic              tmr_load,
    output logic              cmd_req,
    output logic [1:0]        cmd_code,
    output logic              init_done
);
    localparam int SLOTS = NUM_REFRESH + 2;
    localparam int IW    = $clog2(SLOTS);
    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    init_state_e   state, state_n;
    logic [IW-1:0] slot;
    logic          accept, back_idle;

    assign accept    = (cyc_type == CYC_COMMAND) && (cyc_step == '0);
    assign back_idle = (cyc_type == CYC_IDLE);

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (en_s)        state_n = ST_WAIT;
            ST_WAIT:  if (tmr_expired) state_n = ST_ISSUE;
            ST_ISSUE: if (accept)      state_n = ST_BUSY;
            ST_BUSY:  if (back_idle)   state_n = (slot == LAST) ? ST_DONE : ST_ISSUE;
            ST_DONE:                   state_n = ST_DONE;
            default:                   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            state <= state_n;
            if (state == ST_BUSY && back_idle && slot != LAST)
                slot <= slot + 1'b1;
        end
    end

    assign tmr_load  = (state == ST_IDLE) && en_s;
    assign cmd_req   = (state == ST_ISSUE);
    assign cmd_code  = cmd_req ? cmd_for_slot(int'(slot), int'(LAST)) : CMD_NOP;
    assign init_done = (state == ST_DONE);

    // R2: without the synchronized enable nothing leaves idle
    p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !en_s) |=> (state == ST_IDLE && !cmd_req));

    // R4: the opening request of the series is a precharge
    p_first_pre_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmd_req) && slot == '0) |-> (cmd_code == CMD_PRECHARGE));

    // R5: request and code held until a step-0 command cycle is seen
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !((cyc_type == CYC_COMMAND) && (cyc_step == '0)))
            |=> (cmd_req && $stable(cmd_code)));

    // R6: request falls after acceptance
    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && (cyc_type == CYC_COMMAND) && (cyc_step == '0)) |=> !cmd_req);

    // R6: no new request while the shared machine is still busy
    p_wait_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && cyc_type != CYC_IDLE) |=> !cmd_req);

    // R7: no-op code whenever the strobe is low
    p_nop_when_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_req |-> (cmd_code == CMD_NOP));

    // R8: done is sticky and silences further requests
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !cmd_req));

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
    import sdr_init_pkg::*;
#(
    parameter int SYNC_STAGES      = 2,
    parameter int WAIT_CYCLES      = 20,
    parameter int NUM_REFRESH      = 2,
    parameter int STEP_W           = 4,
    parameter int CAS_LAT          = 3,
    parameter int BURST_LEN_CODE   = 3,
    parameter int BURST_INTERLEAVE = 0,
    parameter int SINGLE_WRITE     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_async,
    input  logic [1:0]        cyc_type,
    input  logic [STEP_W-1:0] cyc_step,
    output logic [1:0]        cmd_code,
    output logic              cmd_req,
    output logic [11:0]       mode_word,
    output logic              init_done
);
    localparam mode_word_t MODE_VALUE =
        build_mode(CAS_LAT, BURST_LEN_CODE, BURST_INTERLEAVE, SINGLE_WRITE);

    logic en_s;
    logic tmr_load;
    logic tmr_expired;

    sdr_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (en_async),
        .q       (en_s)
    );

    sdr_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    sdr_init_fsm #(.NUM_REFRESH(NUM_REFRESH), .STEP_W(STEP_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en_s        (en_s),
        .tmr_expired (tmr_expired),
        .cyc_type    (cyc_type),
        .cyc_step    (cyc_step),
        .tmr_load    (tmr_load),
        .cmd_req     (cmd_req),
        .cmd_code    (cmd_code),
        .init_done   (init_done)
    );

    assign mode_word = MODE_VALUE;

    // R8: done only ever follows a finished request, never a fresh one
    p_done_no_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> !cmd_req);

endmodule

// File: tb/test_sdr_init_seq.sv
module test_sdr_init_seq;

    localparam int W  = 20;
    localparam int SS = 2;
    localparam int NR = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_async = 1'b0;
    logic [1:0] cyc_type = 2'b00;
    logic [3:0] cyc_step = 4'd0;
    logic [1:0] cmd_code;
    logic       cmd_req;
    logic [11:0] mode_word;
    logic       init_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    sdr_init_seq #(
        .SYNC_STAGES(SS), .WAIT_CYCLES(W), .NUM_REFRESH(NR), .STEP_W(4),
        .CAS_LAT(2), .BURST_LEN_CODE(2), .BURST_INTERLEAVE(1), .SINGLE_WRITE(1)
    ) i_sdr_init_seq (
        .clk(clk), .rst(rst), .en_async(en_async), .cyc_type(cyc_type),
        .cyc_step(cyc_step), .cmd_code(cmd_code), .cmd_req(cmd_req),
        .mode_word(mode_word), .init_done(init_done)
    );

    // {code[11:10], accept latency[9:6], distractor[5:4], busy hold[3:0]}
    // distractor: 0 idle, 1 data cycle, 2 refresh cycle, 3 command cycle with step 5
    localparam logic [11:0] VEC [4] = '{
        {2'b01, 4'd0, 2'd0, 4'd1},
        {2'b10, 4'd3, 2'd1, 4'd3},
        {2'b10, 4'd2, 2'd3, 4'd0},
        {2'b11, 4'd4, 2'd2, 4'd2}
    };

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        bit saw;
        bit held;
        bit quiet;
        logic [11:0] mode_exp;

        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R9 reset state
        chk(cmd_req == 1'b0, "R9 req after reset", cmd_req, 0);
        chk(cmd_code == 2'b00, "R9 code after reset", cmd_code, 0);
        chk(init_done == 1'b0, "R9 done after reset", init_done, 0);

        // R1 mode word: CL=2, burst code 2, interleaved, single writes
        mode_exp = {2'b00, 1'b1, 2'b00, 3'd2, 1'b1, 3'd2};
        chk(mode_word == mode_exp, "R1 mode word", mode_word, mode_exp);

        // R2 idle while enable low
        saw = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (cmd_req) saw = 1;
        end
        chk(!saw, "R2 no request without enable", saw, 0);

        // R2 start latency
        en_async = 1'b1;
        repeat (SS + W) tick();
        chk(cmd_req == 1'b0, "R2 request not yet", cmd_req, 0);
        tick();
        chk(cmd_req == 1'b1, "R2 first request edge", cmd_req, 1);

        // R4..R8 table walk
        for (int i = 0; i < 4; i++) begin
            logic [11:0] v;
            logic [1:0] code_exp;
            v = VEC[i];
            code_exp = v[11:10];
            chk(cmd_req == 1'b1 && cmd_code == code_exp, "R4 command order",
                cmd_code, code_exp);
            held = 1;
            for (int k = 0; k < int'(v[9:6]); k++) begin
                case (v[5:4])
                    2'd0: begin cyc_type = 2'b00; cyc_step = 4'd0; end
                    2'd1: begin cyc_type = 2'b10; cyc_step = 4'd1; end
                    2'd2: begin cyc_type = 2'b11; cyc_step = 4'd2; end
                    default: begin cyc_type = 2'b01; cyc_step = 4'd5; end
                endcase
                tick();
                if (!cmd_req || cmd_code != code_exp) held = 0;
            end
            chk(held, "R5 request held before acceptance", held, 1);
            cyc_type = 2'b01;
            cyc_step = 4'd0;
            tick();
            chk(cmd_req == 1'b0, "R6 request drops after acceptance", cmd_req, 0);
            quiet = 1;
            for (int k = 0; k < int'(v[3:0]); k++) begin
                cyc_step = 4'(k + 1);
                tick();
                if (cmd_req || cmd_code != 2'b00 || init_done) quiet = 0;
            end
            chk(quiet && cmd_code == 2'b00, "R7 no-op while busy", cmd_code, 0);
            cyc_type = 2'b00;
            cyc_step = 4'd0;
            tick();
            if (i < 3) begin
                chk(cmd_req == 1'b1, "R6 next request after idle", cmd_req, 1);
                chk(init_done == 1'b0, "R8 done not early", init_done, 0);
            end else begin
                chk(init_done == 1'b1, "R8 done after load", init_done, 1);
                chk(cmd_req == 1'b0, "R8 no request at done", cmd_req, 0);
            end
        end

        // R8 sticky done, R3 enable ignored after start
        held = 1;
        for (int k = 0; k < 24; k++) begin
            cyc_type = 2'(k);
            cyc_step = 4'd0;
            en_async = k[2];
            tick();
            if (!init_done || cmd_req) held = 0;
        end
        chk(held, "R8 done sticky without requests", held, 1);

        // R9 reset clears done and restarts
        cyc_type = 2'b00;
        en_async = 1'b1;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(init_done == 1'b0 && cmd_req == 1'b0, "R9 reset clears done", init_done, 0);

        // R3 enable dropped during the settle delay
        repeat (SS + 3) tick();
        en_async = 1'b0;
        saw = 0;
        for (int k = 0; k < 60 && !saw; k++) begin
            tick();
            if (cmd_req) saw = 1;
        end
        chk(saw && cmd_code == 2'b01, "R3 sequence continues after enable drop", saw, 1);

        // R9 reset mid-request, then R2 idle with enable low
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(cmd_req == 1'b0 && cmd_code == 2'b00, "R9 reset clears request", cmd_req, 0);
        saw = 0;
        for (int k = 0; k < 50; k++) begin
            tick();
            if (cmd_req) saw = 1;
        end
        chk(!saw, "R2 stays idle after reset with enable low", saw, 0);

        finish_run();
    end

endmodule